// File: doc/BRIEF.md
# Reference Clock Loss-Detect Switchover Controller

This block picks one of two candidate reference clocks for a downstream glitch-free clock multiplexer. It watches both inputs, flags any input that stops toggling, and moves the multiplexer select to the other input when the selected one dies. It needs no third clock. Each input is watched by logic that runs on the other input, so a live clock always checks its partner. The failover works in either direction and can repeat any number of times.

System logic can also force a change with a switch request. This is the only dependable way to move between inputs whose frequencies differ by more than about 20%. Outside that range the activity detectors are not trustworthy. The two bad flags and the select value are all outputs, so outside logic can apply its own policy on top of the built-in one. The select is held in two toggle flops, one in each clock domain. Each domain can only ever move the select toward its own input, so a dead clock can never take part in a decision.

Top module: `refClkSwitchover`

## Requirements
- R1: While `rstN` is low and just after it is released, `refSel` is 0 (input 0 selected) and both `clkBad0` and `clkBad1` are 0.
- R2: While both inputs toggle at frequencies within 20% of each other, neither bad flag is set. Once an input stops, its bad flag (1 = bad) is still 0 one cycle of the other clock later, and is 1 within 8 cycles of the other clock.
- R3: When the selected input stops and the other input runs, `refSel` changes to the other input (0 = input 0, 1 = input 1) with no external command.
- R4: Automatic failover works from input 0 to 1 and from input 1 to 0, and repeats over any number of fail and recover rounds.
- R5: A bad flag clears after the restarted input has shown 4 toggles of its activity bit, seen from the other clock. A recovered input never causes a switch back while the selected input is healthy.
- R6: Each rising edge of `swReq` flips `refSel` exactly once, however long `swReq` stays high.
- R7: The switch request works when the two inputs run at different frequencies. The bench uses a ratio of 1.5 to 1.
- R8: A switch request is ignored while the input it would select is flagged bad or stopped. `refSel` keeps its value.
- R9: When both inputs stop, `refSel` holds its last value, and a bad flag that is already set stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkRef0 | input | 1 | Candidate reference clock 0 |
| clkRef1 | input | 1 | Candidate reference clock 1 |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| swReq | input | 1 | Asynchronous switch request; each rising edge asks for the other input |
| clkBad0 | output | 1 | 1 while input 0 is judged stopped (registered in the clkRef1 domain) |
| clkBad1 | output | 1 | 1 while input 1 is judged stopped (registered in the clkRef0 domain) |
| refSel | output | 1 | Multiplexer select and active-input indication: 0 = input 0, 1 = input 1 |

## Verification
The properties rely on three things about the inputs:
- Automatic detection is only valid when the two clocks are within 20% of each other.
- `swReq` stays at each level for longer than the synchronizer depth of the slower clock.
- A restarted clock keeps running for long enough to be judged healthy again.

The stimulus follows these rules:
- Both references run at the same period, a quarter period apart, for every automatic failover round.
- The 1.5 to 1 frequency ratio is used only while the manual switch is tested.
- Every request level is held for at least ten bench cycles.
- Clock edges fall on even nanoseconds, and all sampling and driving happens on odd nanoseconds.

// File: rtl/swo_pkg.sv
package swo_pkg;

  // Per-input activity status, produced in the domain of the watching clock.
  typedef struct packed {
    logic bad;   // input judged stopped
    logic seen;  // a toggle of the input's activity bit arrived this cycle
  } actStat_t;

endpackage

// File: rtl/refActivityMon.sv
module refActivityMon
  import swo_pkg::*;
#(
  parameter int STALL_LIMIT   = 2,
  parameter int RECOVER_COUNT = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic     clkSrc,    // clock being watched
  input  logic     clkWatch,  // clock doing the watching
  input  logic     rstN,
  output actStat_t stat
);

  localparam int IDLE_W = $clog2(STALL_LIMIT + 1);
  localparam int REC_W  = $clog2(RECOVER_COUNT + 1);
  localparam int GRACE  = SYNC_STAGES + 2;
  localparam int GR_W   = $clog2(GRACE + 1);

  // Divide-by-2 activity bit in the watched domain.
  logic actBit;
  always_ff @(posedge clkSrc or negedge rstN) begin
    if (!rstN) actBit <= 1'b0;
    else       actBit <= ~actBit;
  end

  // Synchronizer plus one history stage in the watching domain.
  logic [SYNC_STAGES:0] actSync;
  always_ff @(posedge clkWatch or negedge rstN) begin
    if (!rstN) actSync <= '0;
    else       actSync <= {actSync[SYNC_STAGES-1:0], actBit};
  end

  logic seen;
  assign seen = actSync[SYNC_STAGES] ^ actSync[SYNC_STAGES-1];

  logic [GR_W-1:0]   graceCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic [REC_W-1:0]  recCnt;
  logic              bad;
  logic              stallNow;

  assign stallNow = !seen && (graceCnt == '0) &&
                    (idleCnt == IDLE_W'(STALL_LIMIT - 1));

  always_ff @(posedge clkWatch or negedge rstN) begin
    if (!rstN) begin
      graceCnt <= GR_W'(GRACE);
      idleCnt  <= '0;
      recCnt   <= '0;
      bad      <= 1'b0;
    end else begin
      if (graceCnt != '0) graceCnt <= graceCnt - 1'b1;

      if (seen || graceCnt != '0)               idleCnt <= '0;
      else if (idleCnt != IDLE_W'(STALL_LIMIT)) idleCnt <= idleCnt + 1'b1;

      if (!bad) begin
        recCnt <= '0;
        if (stallNow) bad <= 1'b1;
      end else if (seen) begin
        if (recCnt == REC_W'(RECOVER_COUNT - 1)) begin
          bad    <= 1'b0;
          recCnt <= '0;
        end else begin
          recCnt <= recCnt + 1'b1;
        end
      end else if (stallNow) begin
        recCnt <= '0;
      end
    end
  end

  assign stat.bad  = bad;
  assign stat.seen = seen;

  // R2: a flag is raised only after an idle cycle.
  assert_rise_after_idle_R2: assert property (@(posedge clkWatch) disable iff (!rstN)
    $rose(bad) |-> !$past(seen));

  // R2: the idle counter never passes its limit.
  assert_idle_bound_R2: assert property (@(posedge clkWatch) disable iff (!rstN)
    idleCnt <= IDLE_W'(STALL_LIMIT));

  // R5: a flag clears only on observed activity.
  assert_clear_on_toggle_R5: assert property (@(posedge clkWatch) disable iff (!rstN)
    $fell(bad) |-> $past(seen));

endmodule

// File: rtl/switchCtl.sv
module switchCtl
  import swo_pkg::*;
#(
  parameter bit SELF_IDX    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clkOwn,
  input  logic     rstN,
  input  actStat_t peerStat,      // status of the partner input, own domain
  input  logic     ownBadRemote,  // own input's flag, partner domain
  input  logic     peerTog,       // partner toggle flop, partner domain
  input  logic     swReq,
  output logic     ownTog
);

  // The peer toggle view is one stage older than the request edge, so a
  // takeover by the peer is never seen together with the same request.
  logic [SYNC_STAGES:0]   togSync;
  logic [SYNC_STAGES:0]   reqSync;
  logic [SYNC_STAGES-1:0] badSync;

  always_ff @(posedge clkOwn or negedge rstN) begin
    if (!rstN) begin
      togSync <= '0;
      reqSync <= '0;
      badSync <= '0;
    end else begin
      togSync <= {togSync[SYNC_STAGES-1:0], peerTog};
      reqSync <= {reqSync[SYNC_STAGES-1:0], swReq};
      badSync <= {badSync[SYNC_STAGES-2:0], ownBadRemote};
    end
  end

  logic selView, peerActive, reqRise, ownBadSeen;
  logic autoTake, manualTake, takeOver;

  assign selView    = ownTog ^ togSync[SYNC_STAGES];
  assign peerActive = (selView != SELF_IDX);
  assign reqRise    = reqSync[SYNC_STAGES-1] & ~reqSync[SYNC_STAGES];
  assign ownBadSeen = badSync[SYNC_STAGES-1];

  assign autoTake   = peerStat.bad && !peerStat.seen;
  assign manualTake = reqRise && !ownBadSeen;
  assign takeOver   = peerActive && (autoTake || manualTake);

  always_ff @(posedge clkOwn or negedge rstN) begin
    if (!rstN)         ownTog <= 1'b0;
    else if (takeOver) ownTog <= ~ownTog;
  end

  // R6: one step per request, never two in a row.
  assert_single_step_R6: assert property (@(posedge clkOwn) disable iff (!rstN)
    !$stable(ownTog) |=> $stable(ownTog));

  // R8: a request aimed at a flagged input leaves the select alone.
  assert_blocked_request_R8: assert property (@(posedge clkOwn) disable iff (!rstN)
    (reqRise && ownBadSeen && !autoTake) |=> $stable(ownTog));

  // R5: while this input is selected, this domain does not move the select.
  assert_hold_when_selected_R5: assert property (@(posedge clkOwn) disable iff (!rstN)
    !peerActive |=> $stable(ownTog));

endmodule

// File: rtl/refClkSwitchover.sv
module refClkSwitchover
  import swo_pkg::*;
#(
  parameter int STALL_LIMIT   = 2,
  parameter int RECOVER_COUNT = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clkRef0,
  input  logic clkRef1,
  input  logic rstN,
  input  logic swReq,
  output logic clkBad0,
  output logic clkBad1,
  output logic refSel
);

  logic [1:0] refClk;
  assign refClk = {clkRef1, clkRef0};

  actStat_t   stat [2];
  logic [1:0] tog;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    // Input g is watched by the other input's clock.
    refActivityMon #(
      .STALL_LIMIT  (STALL_LIMIT),
      .RECOVER_COUNT(RECOVER_COUNT),
      .SYNC_STAGES  (SYNC_STAGES)
    ) i_mon (
      .clkSrc  (refClk[g]),
      .clkWatch(refClk[1-g]),
      .rstN    (rstN),
      .stat    (stat[g])
    );

    // Domain g can only move the select toward input g.
    switchCtl #(
      .SELF_IDX   (g == 1),
      .SYNC_STAGES(SYNC_STAGES)
    ) i_ctl (
      .clkOwn      (refClk[g]),
      .rstN        (rstN),
      .peerStat    (stat[1-g]),
      .ownBadRemote(stat[g].bad),
      .peerTog     (tog[1-g]),
      .swReq       (swReq),
      .ownTog      (tog[g])
    );
  end

  assign refSel  = tog[0] ^ tog[1];
  assign clkBad0 = stat[0].bad;
  assign clkBad1 = stat[1].bad;

endmodule

// File: tb/test_refClkSwitchover.sv
module test_refClkSwitchover;

  logic clk = 1'b0;
  logic clkRef0 = 1'b0, clkRef1 = 1'b0;
  logic en0 = 1'b1, en1 = 1'b1;
  int   half0 = 4, half1 = 4;
  logic rstN = 1'b0, swReq = 1'b0;
  logic clkBad0, clkBad1, refSel;
  int   nChecks = 0, nFails = 0;
  logic expSel;

  refClkSwitchover i_refClkSwitchover (
    .clkRef0(clkRef0), .clkRef1(clkRef1), .rstN(rstN), .swReq(swReq),
    .clkBad0(clkBad0), .clkBad1(clkBad1), .refSel(refSel)
  );

  // 250 MHz bench clock; reference edges always fall on even nanoseconds.
  always #2 clk = ~clk;
  initial forever begin #(half0); if (en0) clkRef0 = ~clkRef0; end
  initial begin #2; forever begin #(half1); if (en1) clkRef1 = ~clkRef1; end end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic pulseReq(input int hold, input int gap);
    swReq = 1'b1; waitCyc(hold);
    swReq = 1'b0; waitCyc(gap);
  endtask

  task automatic setEn(input logic which, input logic val);
    if (which) en1 = val; else en0 = val;
  endtask

  task automatic finishRun;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got hang expected completion");
    finishRun();
  end

  initial begin
    #21;
    check("R1 sel in reset", refSel, 1'b0);
    check("R1 bad0 in reset", clkBad0, 1'b0);
    check("R1 bad1 in reset", clkBad1, 1'b0);
    #20 rstN = 1'b1;
    waitCyc(40);
    check("R1 sel after reset", refSel, 1'b0);
    check("R2 bad0 idle-free", clkBad0, 1'b0);
    check("R2 bad1 idle-free", clkBad1, 1'b0);

    // R2/R3: input 0 stops while selected.
    en0 = 1'b0;
    waitCyc(2);
    check("R2 bad0 not yet", clkBad0, 1'b0);
    waitCyc(14);
    check("R2 bad0 raised", clkBad0, 1'b1);
    check("R3 failover to 1", refSel, 1'b1);
    check("R2 bad1 stays clear", clkBad1, 1'b0);
    en0 = 1'b1;
    waitCyc(40);
    check("R5 bad0 cleared", clkBad0, 1'b0);
    check("R5 no switch back", refSel, 1'b1);
    expSel = 1'b1;

    // R4: repeated rounds in alternating directions.
    for (int i = 0; i < 4; i++) begin
      setEn(expSel, 1'b0);
      waitCyc(16);
      check("R4 active flagged", expSel ? clkBad1 : clkBad0, 1'b1);
      check("R4 failover", refSel, ~expSel);
      setEn(expSel, 1'b1);
      waitCyc(40);
      check("R5 flag cleared", expSel ? clkBad1 : clkBad0, 1'b0);
      expSel = ~expSel;
      check("R5 select kept", refSel, expSel);
    end

    // R6: holding the request high flips the select once.
    swReq = 1'b1;
    waitCyc(40);
    expSel = ~expSel;
    check("R6 one flip", refSel, expSel);
    waitCyc(20);
    check("R6 held high no more", refSel, expSel);
    swReq = 1'b0;
    waitCyc(20);
    check("R6 release no flip", refSel, expSel);
    pulseReq(10, 30);
    expSel = ~expSel;
    check("R6 second edge", refSel, expSel);

    // R7: manual switch with clkRef1 1.5x slower.
    half1 = 6;
    waitCyc(40);
    for (int k = 0; k < 2; k++) begin
      pulseReq(10, 40);
      expSel = ~expSel;
      check("R7 manual flip at mixed rates", refSel, expSel);
    end
    half1 = 4;
    waitCyc(60);
    check("R7 flags after rate change", clkBad0 | clkBad1, 1'b0);

    // R8: request aimed at a stopped, flagged input.
    setEn(~expSel, 1'b0);
    waitCyc(20);
    check("R8 target flagged", expSel ? clkBad0 : clkBad1, 1'b1);
    pulseReq(10, 30);
    check("R8 request ignored", refSel, expSel);

    // R9: both inputs stop.
    setEn(expSel, 1'b0);
    waitCyc(30);
    check("R9 select holds", refSel, expSel);
    check("R9 flag holds", expSel ? clkBad0 : clkBad1, 1'b1);
    en0 = 1'b1; en1 = 1'b1;
    waitCyc(60);
    check("R9 flags clear after restart", clkBad0 | clkBad1, 1'b0);
    check("R9 select after restart", refSel, expSel);

    // R1: reset in the middle of a run with input 1 selected.
    if (!expSel) begin
      pulseReq(10, 30);
      expSel = 1'b1;
    end
    check("R6 select is 1 before reset", refSel, 1'b1);
    rstN = 1'b0;
    waitCyc(2);
    check("R1 sel during reset", refSel, 1'b0);
    check("R1 flags during reset", clkBad0 | clkBad1, 1'b0);
    rstN = 1'b1;
    waitCyc(40);
    check("R1 sel after re-reset", refSel, 1'b0);

    finishRun();
  end

endmodule